// File: doc/BRIEF.md
# Output Fault Response Controller

This block sequences one regulator channel's reaction to output faults. It receives comparator flags for output overvoltage, undervoltage and overcurrent, a reverse-current-limit flag, and an averaged input-overcurrent warning. From these it drives the top and bottom gate enables, a switching enable, an active-low alert request and four sticky status bits. All configuration arrives on plain input pins, and a 1 µs timebase tick is an input.

Each of the three output faults has its own response code: ignore, latch off, or hiccup retry. Each also has its own deglitch setting in 10 µs steps. Overvoltage also has a hardware path that no response code can bypass. While the overvoltage flag is high, the top gate is blocked and the bottom gate is forced on. If the reverse-current limit trips during that time, the bottom gate is also dropped, and it stays dropped until the overvoltage flag falls. A latched channel waits for a clear pulse. A retrying channel waits a programmed number of milliseconds and then restarts on its own.

Top module: `vout_fault_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is: running (`sw_en`=1), `status`=0 and `alert_n`=1. With no overvoltage, both gate enables are then 1.
- R2: Response codes per fault: 2'b00 ignore, 2'b01 latch off, 2'b10 retry, 2'b11 latch off. An ignored fault still sets its status bit but leaves `sw_en` high.
- R3: A fault qualifies once its flag has been high for `dg`×10 tick pulses in a row. The count restarts whenever the flag is low. With `dg`=0, the fault acts at the first clock edge that samples the flag high. Qualification of a non-ignored fault while running clears `sw_en` after that edge.
- R4: While `ov_flag` is high, `top_en` is 0 in the same cycle. In that case `bot_en` is 1 unless the reverse cutoff of R5 applies. This holds for every OV response code, including 2'b00, and in every channel state.
- R5: While `ov_flag` is high, `rev_lim_flag` high clears `bot_en` at once. `bot_en` then stays 0 until `ov_flag` falls.
- R6: After a latch-off, `sw_en` stays 0 until `clr_pulse` is sampled high. Running resumes after that edge.
- R7: After a retry shutdown, the channel waits the retry delay in milliseconds, each of `US_PER_MS` ticks. It resumes once that delay has elapsed and both `ov_flag` and `oc_flag` are low. `uv_flag` does not hold off the restart.
- R8: If latch-off and retry faults qualify at the same edge, latch-off wins.
- R9: Status bit positions: 0 OV, 1 UV, 2 OC, 3 input-overcurrent warning. Bits 0 to 2 set on qualification, and bit 3 sets whenever `iin_warn_flag` is sampled high. Bits hold until `clr_pulse`. A set and a clear at the same edge leave the bit set.
- R10: `alert_n` is 0 exactly when `status & alert_en` is nonzero.
- R11: A retry delay programmed below 120 ms acts as 120 ms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| ov_flag | input | 1 | Output overvoltage comparator |
| uv_flag | input | 1 | Output undervoltage comparator |
| oc_flag | input | 1 | Output overcurrent flag |
| rev_lim_flag | input | 1 | Reverse current at limit |
| iin_warn_flag | input | 1 | Averaged input overcurrent warning |
| clr_pulse | input | 1 | Clears status and restarts a latched channel |
| ov_resp | input | 2 | OV response code |
| uv_resp | input | 2 | UV response code |
| oc_resp | input | 2 | OC response code |
| ov_dg | input | 3 | OV deglitch, 10 µs steps |
| uv_dg | input | 3 | UV deglitch, 10 µs steps |
| oc_dg | input | 3 | OC deglitch, 10 µs steps |
| retry_ms | input | 17 | Retry delay in ms |
| alert_en | input | 4 | Per-status-bit alert enable |
| top_en | output | 1 | Top switch enable |
| bot_en | output | 1 | Bottom switch enable |
| sw_en | output | 1 | Switching enable |
| alert_n | output | 1 | Active-low alert request |
| status | output | 4 | Sticky fault status |

## Verification
Two pairs of events can land in one cycle. The first is a status clear together with a new fault qualification or input warning. The bench drives `clr_pulse` and a zero-deglitch fault flag on the same negative edge, and expects the bit to survive. The second is latch and retry qualification at once. Undervoltage set to retry and overcurrent set to latch are raised together, and the channel must still be off well past the retry delay. A behavioural model, stepped on every clock, also judges the overvoltage gate override against the programmed response: it covers overlaps with latch-off and with the reverse cutoff.

// File: rtl/fr_pkg.sv
// Shared types for the output fault response controller.
// Assumes three output faults indexed OV=0, UV=1, OC=2.
package fr_pkg;
    localparam int NUM_FLT = 3;
    localparam int FLT_OV  = 0;
    localparam int FLT_UV  = 1;
    localparam int FLT_OC  = 2;
    localparam int NUM_ST  = 4;

    typedef enum logic [1:0] {
        RSP_IGNORE    = 2'b00,
        RSP_LATCH     = 2'b01,
        RSP_RETRY     = 2'b10,
        RSP_LATCH_ALT = 2'b11
    } resp_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'b00,
        ST_LATCH = 2'b01,
        ST_RETRY = 2'b10
    } chan_st_e;
endpackage

// File: rtl/fr_deglitch.sv
// Per-fault deglitch qualifier.
// Counts tick pulses while the flag is high and qualifies the flag once the
// count reaches dg_sel_i * DG_STEP. A low flag restarts the count.
// Assumes tick_i is a single-cycle pulse.
module fr_deglitch #(
    parameter int DG_W    = 3,
    parameter int DG_STEP = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            flag_i,
    input  logic [DG_W-1:0] dg_sel_i,
    output logic            qual_o
);
    localparam int MAX_CNT = ((1 << DG_W) - 1) * DG_STEP;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;

    // Target count for the selected deglitch step.
    assign lim    = CNT_W'(dg_sel_i) * CNT_W'(DG_STEP);
    assign qual_o = flag_i && (cnt_q >= lim);

    // Count ticks while the flag stays high; restart when it drops.
    always_ff @(posedge clk) begin
        if (!rst_n || !flag_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q < lim)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_i |=> (cnt_q == '0));

    // R3
    no_early_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_i) && (dg_sel_i != '0)) |-> !qual_o);
endmodule

// File: rtl/fr_retry_timer.sv
// Hiccup retry delay timer.
// Divides the microsecond tick into milliseconds and compares the elapsed
// count with the programmed delay, clamped from below to MIN_MS.
// Assumes US_PER_MS >= 2; the timer is cleared whenever count_en_i is low.
module fr_retry_timer #(
    parameter int US_PER_MS = 1000,
    parameter int MS_W      = 17,
    parameter int MIN_MS    = 120
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            count_en_i,
    input  logic [MS_W-1:0] delay_ms_i,
    output logic            done_o
);
    localparam int PRE_W = $clog2(US_PER_MS);
    localparam logic [MS_W-1:0]  MIN_V   = MS_W'(MIN_MS);
    localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(US_PER_MS - 1);

    logic [PRE_W-1:0] pre_q;
    logic [MS_W-1:0]  ms_q;
    logic [MS_W-1:0]  eff_ms;

    // Apply the minimum delay.
    assign eff_ms = (delay_ms_i < MIN_V) ? MIN_V : delay_ms_i;
    assign done_o = (ms_q >= eff_ms);

    // Advance the prescaler and the ms count while enabled, holding at done.
    always_ff @(posedge clk) begin
        if (!rst_n || !count_en_i) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (tick_i && !done_o) begin
            if (pre_q == PRE_TOP) begin
                pre_q <= '0;
                ms_q  <= ms_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    // R11
    min_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(count_en_i) |-> !done_o);
endmodule

// File: rtl/fr_status.sv
// Sticky status register and alert request.
// Bits set from set_i and hold until clr_i; a set at the same edge wins.
// alert_n_o is low while any alert-enabled bit is set.
module fr_status #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] alert_en_i,
    output logic [N-1:0] status_o,
    output logic         alert_n_o
);
    logic [N-1:0] st_q;

    // Accumulate fault bits; clear first so a coincident set survives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= (clr_i ? '0 : st_q) | set_i;
        end
    end

    assign status_o  = st_q;
    assign alert_n_o = ~|(st_q & alert_en_i);

    // R9
    set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((st_q & $past(set_i)) == $past(set_i)));

    // R10
    alert_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & alert_en_i)) |=> (!alert_n_o || !$stable(alert_en_i)));
endmodule

// File: rtl/vout_fault_seq.sv
// Output fault response controller for one regulator channel.
// Deglitches OV/UV/OC, picks the shutdown response per fault, runs the
// latch-off / hiccup state machine and applies the hardware OV gate override
// with reverse-current cutoff. Assumes all flag inputs are synchronous to clk.
module vout_fault_seq #(
    parameter int DG_W         = 3,
    parameter int DG_STEP_US   = 10,
    parameter int US_PER_MS    = 1000,
    parameter int RETRY_W      = 17,
    parameter int MIN_RETRY_MS = 120
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_us,
    input  logic               ov_flag,
    input  logic               uv_flag,
    input  logic               oc_flag,
    input  logic               rev_lim_flag,
    input  logic               iin_warn_flag,
    input  logic               clr_pulse,
    input  logic [1:0]         ov_resp,
    input  logic [1:0]         uv_resp,
    input  logic [1:0]         oc_resp,
    input  logic [DG_W-1:0]    ov_dg,
    input  logic [DG_W-1:0]    uv_dg,
    input  logic [DG_W-1:0]    oc_dg,
    input  logic [RETRY_W-1:0] retry_ms,
    input  logic [3:0]         alert_en,
    output logic               top_en,
    output logic               bot_en,
    output logic               sw_en,
    output logic               alert_n,
    output logic [3:0]         status
);
    import fr_pkg::*;

    logic [NUM_FLT-1:0] flt_flag;
    logic [DG_W-1:0]    flt_dg   [NUM_FLT];
    logic [1:0]         flt_resp [NUM_FLT];
    logic [NUM_FLT-1:0] qual;
    logic               want_latch;
    logic               want_retry;
    logic               retry_done;
    logic               run_w;
    logic               rev_cut_q;
    chan_st_e           st_q;
    chan_st_e           st_d;

    assign flt_flag[FLT_OV] = ov_flag;
    assign flt_flag[FLT_UV] = uv_flag;
    assign flt_flag[FLT_OC] = oc_flag;
    assign flt_dg[FLT_OV]   = ov_dg;
    assign flt_dg[FLT_UV]   = uv_dg;
    assign flt_dg[FLT_OC]   = oc_dg;
    assign flt_resp[FLT_OV] = ov_resp;
    assign flt_resp[FLT_UV] = uv_resp;
    assign flt_resp[FLT_OC] = oc_resp;

    for (genvar g = 0; g < NUM_FLT; g++) begin : g_dg
        fr_deglitch #(
            .DG_W    (DG_W),
            .DG_STEP (DG_STEP_US)
        ) u_dg (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick_us),
            .flag_i   (flt_flag[g]),
            .dg_sel_i (flt_dg[g]),
            .qual_o   (qual[g])
        );
    end

    // Sort qualified faults into latch and retry requests.
    always_comb begin
        want_latch = 1'b0;
        want_retry = 1'b0;
        for (int i = 0; i < NUM_FLT; i++) begin
            if (qual[i]) begin
                unique case (resp_e'(flt_resp[i]))
                    RSP_LATCH, RSP_LATCH_ALT: want_latch = 1'b1;
                    RSP_RETRY:                want_retry = 1'b1;
                    default:                  ;
                endcase
            end
        end
    end

    fr_retry_timer #(
        .US_PER_MS (US_PER_MS),
        .MS_W      (RETRY_W),
        .MIN_MS    (MIN_RETRY_MS)
    ) u_retry (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_us),
        .count_en_i (st_q == ST_RETRY),
        .delay_ms_i (retry_ms),
        .done_o     (retry_done)
    );

    // Channel state transitions; latch-off outranks retry.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (want_latch)      st_d = ST_LATCH;
                else if (want_retry) st_d = ST_RETRY;
            end
            ST_LATCH: if (clr_pulse) st_d = ST_RUN;
            ST_RETRY: if (retry_done && !ov_flag && !oc_flag) st_d = ST_RUN;
            default:  st_d = ST_RUN;
        endcase
    end

    // Channel state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    // Remember a reverse-current trip for as long as OV persists.
    always_ff @(posedge clk) begin
        if (!rst_n || !ov_flag) rev_cut_q <= 1'b0;
        else if (rev_lim_flag)  rev_cut_q <= 1'b1;
    end

    assign run_w  = (st_q == ST_RUN);
    assign sw_en  = run_w;
    assign top_en = run_w && !ov_flag;
    assign bot_en = ov_flag ? !(rev_cut_q || rev_lim_flag) : run_w;

    fr_status #(
        .N (NUM_ST)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_pulse),
        .set_i      ({iin_warn_flag, qual[FLT_OC], qual[FLT_UV], qual[FLT_OV]}),
        .alert_en_i (alert_en),
        .status_o   (status),
        .alert_n_o  (alert_n)
    );

    // R4
    ov_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ov_flag) && !rev_lim_flag) |-> (!top_en && bot_en));

    // R5
    rev_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_flag && rev_lim_flag) |=> (!ov_flag || !bot_en));

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LATCH && !clr_pulse) |=> !sw_en);

    // R7
    retry_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RETRY && !retry_done) |=> !sw_en);

    // R8
    latch_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && want_latch && want_retry) |=> (st_q == ST_LATCH));
endmodule

// File: tb/vout_fault_seq_bench.sv
module vout_fault_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int US_MS      = 4;
    localparam int MIN_MS     = 120;
    localparam int WATCHDOG   = 150000;

    logic clk = 0;
    logic rst_n = 0;
    logic tick_us = 0;
    logic ov_flag = 0, uv_flag = 0, oc_flag = 0, rev_lim_flag = 0, iin_warn_flag = 0;
    logic clr_pulse = 0;
    logic [1:0] ov_resp = 0, uv_resp = 0, oc_resp = 0;
    logic [2:0] ov_dg = 0, uv_dg = 0, oc_dg = 0;
    logic [16:0] retry_ms = 17'd200;
    logic [3:0] alert_en = 4'hF;
    logic top_en, bot_en, sw_en, alert_n;
    logic [3:0] status;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    vout_fault_seq #(.US_PER_MS(US_MS), .MIN_RETRY_MS(MIN_MS)) u_vout_fault_seq (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .ov_flag(ov_flag), .uv_flag(uv_flag),
        .oc_flag(oc_flag), .rev_lim_flag(rev_lim_flag), .iin_warn_flag(iin_warn_flag),
        .clr_pulse(clr_pulse), .ov_resp(ov_resp), .uv_resp(uv_resp), .oc_resp(oc_resp),
        .ov_dg(ov_dg), .uv_dg(uv_dg), .oc_dg(oc_dg), .retry_ms(retry_ms),
        .alert_en(alert_en), .top_en(top_en), .bot_en(bot_en), .sw_en(sw_en),
        .alert_n(alert_n), .status(status));

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) tick_us <= ~tick_us;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state
    int m_st = 0, m_pre = 0, m_ms = 0;
    int dgc[3];
    bit m_rc = 0;
    bit [3:0] m_stat = 0;

    function automatic bit fl(int i);
        return (i == 0) ? ov_flag : (i == 1) ? uv_flag : oc_flag;
    endfunction
    function automatic int rs(int i);
        return (i == 0) ? int'(ov_resp) : (i == 1) ? int'(uv_resp) : int'(oc_resp);
    endfunction
    function automatic int dl(int i);
        return 10 * ((i == 0) ? int'(ov_dg) : (i == 1) ? int'(uv_dg) : int'(oc_dg));
    endfunction

    // Step the model at each edge, then compare outputs late in the cycle.
    always @(posedge clk) begin
        bit q[3];
        int nst, eff;
        bit wl, wr, e_run, e_bot;
        eff = (int'(retry_ms) < MIN_MS) ? MIN_MS : int'(retry_ms);
        if (!rst_n) begin
            m_st = 0; m_pre = 0; m_ms = 0; m_rc = 0; m_stat = 0;
            for (int i = 0; i < 3; i++) dgc[i] = 0;
        end else begin
            for (int i = 0; i < 3; i++) q[i] = fl(i) && (dgc[i] >= dl(i));
            for (int i = 0; i < 3; i++) begin
                if (!fl(i)) dgc[i] = 0;
                else if (tick_us && dgc[i] < dl(i)) dgc[i]++;
            end
            nst = m_st; wl = 0; wr = 0;
            for (int i = 0; i < 3; i++)
                if (q[i]) begin
                    if (rs(i) == 1 || rs(i) == 3) wl = 1;
                    else if (rs(i) == 2) wr = 1;
                end
            if (m_st == 0) begin
                if (wl) nst = 1; else if (wr) nst = 2;
            end else if (m_st == 1) begin
                if (clr_pulse) nst = 0;
            end else if (m_ms >= eff && !ov_flag && !oc_flag) nst = 0;
            if (m_st != 2) begin m_pre = 0; m_ms = 0; end
            else if (tick_us && m_ms < eff) begin
                if (m_pre == US_MS - 1) begin m_pre = 0; m_ms++; end
                else m_pre++;
            end
            if (!ov_flag) m_rc = 0; else if (rev_lim_flag) m_rc = 1;
            if (clr_pulse) m_stat = 0;
            m_stat |= {iin_warn_flag, q[2], q[1], q[0]};
            m_st = nst;
        end
        #(CLK_PERIOD*7/10);
        e_run = (m_st == 0);
        e_bot = ov_flag ? !(m_rc || rev_lim_flag) : e_run;
        chk("R3 sw_en", sw_en, e_run);
        chk("R4 top_en", top_en, e_run && !ov_flag);
        chk("R5 bot_en", bot_en, e_bot);
        chk("R9 status", status, m_stat);
        chk("R10 alert_n", alert_n, (m_stat & alert_en) == 0);
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic look();
        #1;
    endtask
    task automatic clear();
        clr_pulse = 1; cyc(1); clr_pulse = 0; cyc(1);
    endtask

    initial begin
        cyc(4); rst_n = 1; cyc(1); look();
        // R1 reset state
        chk("R1 sw_en", sw_en, 1); chk("R1 status", status, 0);
        chk("R1 alert_n", alert_n, 1); chk("R1 gates", {top_en, bot_en}, 3);

        // R2 ignored UV sets status only
        uv_flag = 1; cyc(2); uv_flag = 0; cyc(1); look();
        chk("R2 ignore sw_en", sw_en, 1); chk("R2 status", status[1], 1);
        chk("R10 alert low", alert_n, 0);
        clear(); look(); chk("R9 cleared", status, 0);

        // R3 glitch shorter than deglitch, then a held OC with latch-off
        oc_resp = 2'b01; oc_dg = 3'd2;
        oc_flag = 1; cyc(15); oc_flag = 0; cyc(2); look();
        chk("R3 glitch", {sw_en, status[2]}, 2);
        oc_flag = 1; cyc(60); look();
        chk("R3 qualified", {sw_en, status[2]}, 1);
        oc_flag = 0; cyc(50); look(); chk("R6 latched", sw_en, 0);
        ov_flag = 1; cyc(1); look();
        chk("R4 ov while latched", {top_en, bot_en}, 1);
        ov_flag = 0; cyc(2);
        clear(); look(); chk("R6 restart", sw_en, 1);

        // R4/R5 OV pull-down only with reverse cutoff
        ov_flag = 1; look(); chk("R4 same cycle", {top_en, bot_en, sw_en}, 3);
        cyc(3); rev_lim_flag = 1; look(); chk("R5 cut", bot_en, 0);
        cyc(1); rev_lim_flag = 0; cyc(3); look(); chk("R5 held", bot_en, 0);
        ov_flag = 0; cyc(1); look(); chk("R5 release", {top_en, bot_en}, 3);
        clear();

        // R11/R7 OV retry with clamped delay
        ov_resp = 2'b10; retry_ms = 17'd5;
        ov_flag = 1; cyc(10); ov_flag = 0; cyc(880); look();
        chk("R11 clamp", sw_en, 0);
        cyc(200); look(); chk("R7 restart", sw_en, 1);
        ov_resp = 2'b00; clear();

        // R7 restart held off by a lingering OC
        uv_resp = 2'b10; oc_resp = 2'b00; oc_dg = 0; retry_ms = 17'd121;
        uv_flag = 1; cyc(2); uv_flag = 0; oc_flag = 1; cyc(1100); look();
        chk("R7 wait oc", sw_en, 0);
        oc_flag = 0; cyc(3); look(); chk("R7 after oc", sw_en, 1);
        clear();

        // R8 latch and retry in the same edge
        oc_resp = 2'b01;
        uv_flag = 1; oc_flag = 1; cyc(3); uv_flag = 0; oc_flag = 0; cyc(1100); look();
        chk("R8 latch wins", sw_en, 0);
        clear(); look(); chk("R8 clr restart", sw_en, 1);

        // R9/R10 coincident set and clear, masked alert
        uv_resp = 2'b00; alert_en = 4'b0111; cyc(1);
        uv_flag = 1; clr_pulse = 1; cyc(1); uv_flag = 0; clr_pulse = 0; cyc(1); look();
        chk("R9 set beats clr", status, 4'b0010); chk("R10 enabled", alert_n, 0);
        clear(); iin_warn_flag = 1; cyc(1); iin_warn_flag = 0; cyc(1); look();
        chk("R9 iin bit", status, 4'b1000); chk("R10 masked", alert_n, 1);
        cyc(4);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule